// File: doc/BRIEF.md
# Branch Resolution Unit

This unit settles the outcome of one branch operation per accepted transfer in a 64-bit core whose instructions are four bytes wide. A decoder upstream has already sorted the instruction into a kind and pulled out its fields. The unit reads these inputs:

- the current instruction address;
- the 32-bit condition register;
- a count operand on the first special-register port;
- a link or target operand on the second port.

From these it works out whether control leaves the sequential path and where it goes. It also returns the decremented count with a write flag and the return address with a write flag.

Operands enter through a valid/ready handshake. Results come out one cycle later from a single output register that has its own valid/ready pair. A result that the consumer has not taken is held unchanged, and new input is refused until the consumer takes it. Every output carries its own flag, so the register-write stage sees directly whether the count or the link register is to be written.

Top module: `br_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is low after that edge. `in_ready` is high whenever `out_valid` is low.
- R2: For `op_kind` 0 (immediate), the branch is always taken. The byte offset is `op_disp` (24 bits, signed) times 4. With `op_abs` clear, the target is `cia` plus this offset. With `op_abs` set, the target is the offset sign-extended to 64 bits.
- R3: `lr_ok` equals `op_link` of the accepted operation. When `lr_ok` is set, `lr` holds `cia + 4`.
- R4: For `op_kind` 1 (conditional), the offset is `op_disp[13:0]` (signed) times 4, and `op_abs` applies as in R2. `op_disp[23:14]` are ignored. BI value b selects `cr[31-b]`. If `op_bo[4]` is set, the condition bit is ignored. Otherwise the selected bit must equal `op_bo[3]`.
- R5: For kinds 1, 2 and 4, clearing `op_bo[2]` decrements the count. In that case `cnt_ok` is set and `cnt = spr1 - 1`. The decremented value must then be zero if `op_bo[1]` is set, or nonzero if it is clear, for the branch to be taken. If `op_bo[2]` is set, `cnt_ok` is clear and the count takes no part in the decision.
- R6: Kind 2 (to link) and kind 4 (to target) branch to `spr2` with bits 1:0 forced to zero.
- R7: Kind 3 (to count) branches to `spr1` with bits 1:0 forced to zero. It never decrements the count (`cnt_ok` clear), even when `op_bo[2]` is clear, and its count test is treated as satisfied.
- R8: `op_hint` has no effect on any output.
- R9: `nia_ok` is set exactly when the branch is taken. When the branch is not taken, `nia` holds `cia + 4`. Kinds 5 to 7 are never taken.
- R10: The handshake is `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op_kind | input | 3 | 0 immediate, 1 conditional, 2 to link, 3 to count, 4 to target |
| op_abs | input | 1 | Offset is an absolute address |
| op_link | input | 1 | Write the return address |
| op_bo | input | 5 | Branch options |
| op_bi | input | 5 | Condition bit select |
| op_hint | input | 2 | Prediction hint, no effect |
| op_disp | input | 24 | Word displacement field |
| cia | input | 64 | Current instruction address |
| cr | input | 32 | Condition register |
| spr1 | input | 64 | Count operand |
| spr2 | input | 64 | Link or target operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| nia_ok | output | 1 | Branch taken |
| nia | output | 64 | Next instruction address |
| cnt_ok | output | 1 | Count is to be written |
| cnt | output | 64 | Decremented count |
| lr_ok | output | 1 | Link register is to be written |
| lr | output | 64 | Return address |

## Verification
The hardest case to reach from the ports is a register-indirect branch that also decrements the count. In that case the condition bit, the count test and the indirect operand all bear on a single outcome. The stimulus table therefore contains vectors that make each of the three tests decide on its own: a count of one that falls to zero, a cleared bit compared against a cleared sense, and a to-count branch carrying the illegal decrement encoding. A directed sequence then stalls the consumer while a second operation is offered, to show that the held result survives.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam int XLEN       = 64;
    localparam int CRW        = 32;
    localparam int LI_W       = 24;
    localparam int BD_W       = 14;
    localparam int BO_W       = 5;
    localparam int BI_W       = 5;
    localparam int INSN_BYTES = 4;

    typedef enum logic [2:0] {
        K_IMM  = 3'd0,
        K_COND = 3'd1,
        K_LINK = 3'd2,
        K_CNT  = 3'd3,
        K_TGT  = 3'd4
    } br_kind_e;

    typedef struct packed {
        logic            nia_ok;
        logic [XLEN-1:0] nia;
        logic            cnt_ok;
        logic [XLEN-1:0] cnt;
        logic            lr_ok;
        logic [XLEN-1:0] lr;
    } br_result_t;

    function automatic logic [XLEN-1:0] clear_low2(input logic [XLEN-1:0] a);
        return {a[XLEN-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/br_target.sv
module br_target
    import br_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int LIW = LI_W,
    parameter int BDW = BD_W
) (
    input  logic [2:0]   kind,
    input  logic         abs_sel,
    input  logic [LIW-1:0] disp,
    input  logic [W-1:0] cia,
    input  logic [W-1:0] spr1,
    input  logic [W-1:0] spr2,
    output logic [W-1:0] target
);
    localparam int LI_PAD = W - LIW - 2;
    localparam int BD_PAD = W - BDW - 2;

    logic [W-1:0] off_long, off_short, off_sel, rel_or_abs;

    always_comb begin
        off_long  = {{LI_PAD{disp[LIW-1]}}, disp, 2'b00};
        off_short = {{BD_PAD{disp[BDW-1]}}, disp[BDW-1:0], 2'b00};
        off_sel   = (kind == K_IMM) ? off_long : off_short;
        rel_or_abs = abs_sel ? off_sel : cia + off_sel;
        case (kind)
            K_IMM, K_COND: target = rel_or_abs;
            K_CNT:         target = clear_low2(spr1);
            K_LINK, K_TGT: target = clear_low2(spr2);
            default:       target = cia + W'(INSN_BYTES);
        endcase
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int W   = XLEN,
    parameter int CW  = CRW,
    parameter int BOW = BO_W,
    parameter int BIW = BI_W
) (
    input  logic [2:0]     kind,
    input  logic [BOW-1:0] bo,
    input  logic [BIW-1:0] bi,
    input  logic [CW-1:0]  cr,
    input  logic [W-1:0]   spr1,
    output logic           take,
    output logic           dec_en,
    output logic [W-1:0]   cnt_next
);
    logic [BIW-1:0] idx;
    logic cond_ok, ctr_ok, cond_bit;

    always_comb begin
        idx      = BIW'(CW - 1) - bi;
        cond_bit = cr[idx];
        dec_en   = (kind == K_COND || kind == K_LINK || kind == K_TGT) && !bo[2];
        cnt_next = spr1 - W'(1);
        ctr_ok   = !dec_en || ((cnt_next == '0) == bo[1]);
        cond_ok  = bo[4] || (cond_bit == bo[3]);
        case (kind)
            K_IMM:                        take = 1'b1;
            K_COND, K_LINK, K_CNT, K_TGT: take = ctr_ok && cond_ok;
            default:                      take = 1'b0;
        endcase
    end

    // the to-count form must never request a count write
    always_comb begin
        if (kind == K_CNT) a_no_cnt_dec_r7: assert (!dec_en);
    end
endmodule

// File: rtl/br_exec_unit.sv
module br_exec_unit
    import br_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [2:0]  op_kind,
    input  logic        op_abs,
    input  logic        op_link,
    input  logic [4:0]  op_bo,
    input  logic [4:0]  op_bi,
    input  logic [1:0]  op_hint,
    input  logic [23:0] op_disp,
    input  logic [63:0] cia,
    input  logic [31:0] cr,
    input  logic [63:0] spr1,
    input  logic [63:0] spr2,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        nia_ok,
    output logic [63:0] nia,
    output logic        cnt_ok,
    output logic [63:0] cnt,
    output logic        lr_ok,
    output logic [63:0] lr
);
    localparam int W = XLEN;

    logic         fire, take, dec_en;
    logic [W-1:0] target, cnt_next, seq_addr;
    br_result_t   nxt, res;
    logic         unused_hint;

    assign unused_hint = ^op_hint;
    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;
    assign seq_addr = cia + W'(INSN_BYTES);

    br_target #(.W(W), .LIW(LI_W), .BDW(BD_W)) u_tgt (
        .kind(op_kind), .abs_sel(op_abs), .disp(op_disp), .cia(cia),
        .spr1(spr1), .spr2(spr2), .target(target)
    );

    br_cond #(.W(W), .CW(CRW), .BOW(BO_W), .BIW(BI_W)) u_cond (
        .kind(op_kind), .bo(op_bo), .bi(op_bi), .cr(cr), .spr1(spr1),
        .take(take), .dec_en(dec_en), .cnt_next(cnt_next)
    );

    always_comb begin
        nxt.nia_ok = take;
        nxt.nia    = take ? target : seq_addr;
        nxt.cnt_ok = dec_en;
        nxt.cnt    = cnt_next;
        nxt.lr_ok  = op_link;
        nxt.lr     = seq_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '0;
        end else if (fire) begin
            out_valid <= 1'b1;
            res       <= nxt;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign nia_ok = res.nia_ok;
    assign nia    = res.nia;
    assign cnt_ok = res.cnt_ok;
    assign cnt    = res.cnt;
    assign lr_ok  = res.lr_ok;
    assign lr     = res.lr;

    p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

    p_imm_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && op_kind == K_IMM) |=> nia_ok);

    p_link_r3: assert property (@(posedge clk) disable iff (rst)
        fire |=> (lr_ok == $past(op_link)));

    p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && (op_kind == K_LINK || op_kind == K_TGT || op_kind == K_CNT) && take)
        |=> (nia[1:0] == 2'b00));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(nia) && $stable(nia_ok)
                                       && $stable(cnt) && $stable(lr_ok)));
endmodule

// File: tb/br_exec_unit_test.sv
module br_exec_unit_test;
    logic clk = 0, rst = 1;
    logic in_valid = 0, out_ready = 1;
    logic [2:0] op_kind = 0;
    logic op_abs = 0, op_link = 0;
    logic [4:0] op_bo = 0, op_bi = 0;
    logic [1:0] op_hint = 0;
    logic [23:0] op_disp = 0;
    logic [63:0] cia = 0, spr1 = 0, spr2 = 0;
    logic [31:0] cr = 0;
    logic in_ready, out_valid, nia_ok, cnt_ok, lr_ok;
    logic [63:0] nia, cnt, lr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    br_exec_unit uut (.*);

    typedef struct packed {
        logic [15:0] tag;
        logic [2:0]  kind;
        logic        ab, lk;
        logic [4:0]  bo, bi;
        logic [1:0]  hint;
        logic [23:0] disp;
        logic [63:0] pc;
        logic [31:0] crv;
        logic [63:0] s1, s2;
        logic        e_nok;
        logic [63:0] e_nia;
        logic        e_cok;
        logic [63:0] e_cnt;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{"R2", 3'd0, 1'b0, 1'b0, 5'b00000, 5'd0, 2'd0, 24'h000010, 64'h1000, 32'h0, 64'h0, 64'h0, 1'b1, 64'h1040, 1'b0, 64'h0},
        '{"R2", 3'd0, 1'b0, 1'b1, 5'b00000, 5'd0, 2'd0, 24'hFFFFFF, 64'h1000, 32'h0, 64'h0, 64'h0, 1'b1, 64'hFFC, 1'b0, 64'h0},
        '{"R2", 3'd0, 1'b1, 1'b1, 5'b00000, 5'd0, 2'd0, 24'h800000, 64'h1000, 32'h0, 64'h0, 64'h0, 1'b1, 64'hFFFFFFFFFE000000, 1'b0, 64'h0},
        '{"R4", 3'd1, 1'b0, 1'b0, 5'b01100, 5'd0, 2'd0, 24'hAB3FFF, 64'h1000, 32'h80000000, 64'h0, 64'h0, 1'b1, 64'hFFC, 1'b0, 64'h0},
        '{"R9", 3'd1, 1'b0, 1'b0, 5'b01100, 5'd5, 2'd0, 24'h000004, 64'h1000, 32'hFBFFFFFF, 64'h0, 64'h0, 1'b0, 64'h1004, 1'b0, 64'h0},
        '{"R4", 3'd1, 1'b0, 1'b0, 5'b00100, 5'd5, 2'd0, 24'h000003, 64'h1000, 32'hFBFFFFFF, 64'h0, 64'h0, 1'b1, 64'h100C, 1'b0, 64'h0},
        '{"R5", 3'd1, 1'b0, 1'b0, 5'b10000, 5'd0, 2'd0, 24'h000002, 64'h1000, 32'h0, 64'h5, 64'h0, 1'b1, 64'h1008, 1'b1, 64'h4},
        '{"R5", 3'd1, 1'b0, 1'b0, 5'b10000, 5'd0, 2'd0, 24'h000002, 64'h1000, 32'h0, 64'h1, 64'h0, 1'b0, 64'h1004, 1'b1, 64'h0},
        '{"R5", 3'd1, 1'b0, 1'b0, 5'b10010, 5'd0, 2'd0, 24'h000002, 64'h1000, 32'h0, 64'h1, 64'h0, 1'b1, 64'h1008, 1'b1, 64'h0},
        '{"R6", 3'd2, 1'b0, 1'b1, 5'b10100, 5'd0, 2'd2, 24'h0, 64'h1000, 32'h0, 64'h0, 64'h12345677, 1'b1, 64'h12345674, 1'b0, 64'h0},
        '{"R8", 3'd2, 1'b0, 1'b1, 5'b10100, 5'd0, 2'd1, 24'h0, 64'h1000, 32'h0, 64'h0, 64'h12345677, 1'b1, 64'h12345674, 1'b0, 64'h0},
        '{"R6", 3'd4, 1'b0, 1'b0, 5'b10100, 5'd0, 2'd3, 24'h0, 64'h1000, 32'h0, 64'h0, 64'hFFFF000000000003, 1'b1, 64'hFFFF000000000000, 1'b0, 64'h0},
        '{"R7", 3'd3, 1'b0, 1'b0, 5'b10000, 5'd0, 2'd0, 24'h0, 64'h1000, 32'h0, 64'h2003, 64'h0, 1'b1, 64'h2000, 1'b0, 64'h0},
        '{"R4", 3'd1, 1'b1, 1'b0, 5'b10100, 5'd0, 2'd0, 24'h000100, 64'h1000, 32'h0, 64'h0, 64'h0, 1'b1, 64'h400, 1'b0, 64'h0},
        '{"R5", 3'd2, 1'b0, 1'b0, 5'b00000, 5'd0, 2'd0, 24'h0, 64'h1000, 32'h0, 64'h2, 64'h8888, 1'b1, 64'h8888, 1'b1, 64'h1},
        '{"R9", 3'd5, 1'b0, 1'b0, 5'b10100, 5'd0, 2'd0, 24'h000010, 64'h1000, 32'h0, 64'h0, 64'h0, 1'b0, 64'h1004, 1'b0, 64'h0}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_kind = v.kind; op_abs = v.ab; op_link = v.lk; op_bo = v.bo;
        op_bi = v.bi; op_hint = v.hint; op_disp = v.disp; cia = v.pc;
        cr = v.crv; spr1 = v.s1; spr2 = v.s2;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'h0);
        chk("R1 in_ready", 64'(in_ready), 64'h1);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            in_valid = 1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 0;
            chk({string'(VT[i].tag), " valid"}, 64'(out_valid), 64'h1);
            chk({string'(VT[i].tag), " nia_ok R9"}, 64'(nia_ok), 64'(VT[i].e_nok));
            chk({string'(VT[i].tag), " nia"}, nia, VT[i].e_nia);
            chk({string'(VT[i].tag), " cnt_ok R5"}, 64'(cnt_ok), 64'(VT[i].e_cok));
            if (VT[i].e_cok) chk({string'(VT[i].tag), " cnt R5"}, cnt, VT[i].e_cnt);
            chk({string'(VT[i].tag), " lr_ok R3"}, 64'(lr_ok), 64'(VT[i].lk));
            if (VT[i].lk) chk({string'(VT[i].tag), " lr R3"}, lr, VT[i].pc + 64'd4);
        end

        // R10: stall holds result and blocks input
        @(negedge clk);
        out_ready = 0;
        drive(VT[0]);
        in_valid = 1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 stalled in_ready", 64'(in_ready), 64'h0);
        drive(VT[9]);
        @(posedge clk);
        @(negedge clk);
        chk("R10 held nia", nia, 64'h1040);
        chk("R10 held lr_ok", 64'(lr_ok), 64'h0);
        out_ready = 1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        chk("R10 next nia", nia, 64'h12345674);
        @(posedge clk);
        @(negedge clk);
        chk("R10 drained", 64'(out_valid), 64'h0);

        // R1: reset mid-run clears the output
        drive(VT[0]);
        in_valid = 1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset clears", 64'(out_valid), 64'h0);
        rst = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule